// File: doc/BRIEF.md
# Two-Set Longest-Match Priority Resolver

This block sits at the tail of a lookup engine that searches two disjoint prefix sets in parallel. Each set is searched by its own pipeline, and the two pipelines have different stage counts, so the answer for one lookup leaves them at different times. The resolver delays the stream from the shorter pipeline by a fixed number of cycles so both answers for the same lookup meet, then picks one next hop. Because each set is disjoint, each yields at most one match. Any match in the first set is always longer than any match in the second. So the choice is a fixed priority and needs no length compare. When neither set matches, a configurable default route is returned.

Two independent lanes are resolved every clock, one per port of the dual-ported search memories. Valid flags travel through the delay line together with the data. A lane's output is valid only when both aligned inputs are valid. An aligned pair in which exactly one side is valid points to a broken pipeline alignment. It drives a small state machine into a fault state that holds until reset. The machine has two states: CLEAN and FAULT. Its transitions are CLEAN to FAULT on any lane mismatch, CLEAN to CLEAN otherwise, and FAULT to FAULT always.

Top module: `lpm_pair_resolver`

## Requirements
- R1: After reset, `res_valid` and `res_hit` are all zero, and `err_sticky` is 0.
- R2: When both aligned inputs of a lane are valid and the first-set input reports a hit, the result is hit=1 with the first-set next hop, whatever the second set reports.
- R3: When both aligned inputs are valid, the first set misses and the second set hits, the result is hit=1 with the second-set next hop.
- R4: When both aligned inputs are valid and neither set hits, the result is hit=0 and the next hop equals `DEFAULT_NH` (8'hEE by default).
- R5: A second-set input given in cycle t is paired with the first-set input given in cycle t+DLY, where `DLY` is the depth parameter (0 to 4, default 2). The result appears on the outputs after the clock edge that ends cycle t+DLY.
- R6: The two lanes are resolved in the same cycle, independently of each other. Lane i uses bits [i] of the flag buses and bits [i*NH_W +: NH_W] of the next-hop buses.
- R7: `res_valid` of a lane is 1 only when both of its aligned inputs are valid. While `res_valid` is 0, `res_hit` is 0.
- R8: When in any lane exactly one of the two aligned inputs is valid, `err_sticky` goes to 1 after that clock edge and stays 1 until reset.
- R9: Aligned pairs in which both sides are invalid, or both are valid, never set `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s1_valid | input | LANES | First-set (longer pipeline) result valid, per lane |
| s1_hit | input | LANES | First-set match found, per lane |
| s1_nh | input | LANES*NH_W | First-set next hop, per lane |
| s2_valid | input | LANES | Second-set (shorter pipeline) result valid, per lane |
| s2_hit | input | LANES | Second-set match found, per lane |
| s2_nh | input | LANES*NH_W | Second-set next hop, per lane |
| res_valid | output | LANES | Resolved result valid, per lane |
| res_hit | output | LANES | Some prefix matched, per lane |
| res_nh | output | LANES*NH_W | Resolved next hop, per lane |
| err_sticky | output | 1 | Alignment fault seen since reset |

## Verification
Two functions can act in the same cycle: the priority choice of a lane and the alignment fault check. The second-set stream is fed DLY cycles ahead of the first-set stream, so every aligned pair in the vector table is resolved while the fault machine watches the same pair. The table must finish with correct next hops and with `err_sticky` still low. After that, a lone first-set valid is driven on one lane. The judge is that the lane stays invalid in that same cycle while the fault flag rises, and that the flag holds through idle cycles until reset.

// File: rtl/lpm_res_pkg.sv
package lpm_res_pkg;
    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } err_state_e;
endpackage

// File: rtl/lpm_res_delay.sv
module lpm_res_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_shift
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign dout = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/lpm_res_lane.sv
module lpm_res_lane #(
    parameter int              NH_W       = 8,
    parameter logic [NH_W-1:0] DEFAULT_NH = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a1_v,
    input  logic            a1_h,
    input  logic [NH_W-1:0] a1_nh,
    input  logic            a2_v,
    input  logic            a2_h,
    input  logic [NH_W-1:0] a2_nh,
    output logic            mismatch,
    output logic            o_v,
    output logic            o_h,
    output logic [NH_W-1:0] o_nh
);
    logic            both_v;
    logic            pick_h;
    logic [NH_W-1:0] pick_nh;

    always_comb begin
        both_v   = a1_v & a2_v;
        mismatch = a1_v ^ a2_v;
        pick_h   = both_v & (a1_h | a2_h);
        if (a1_h)      pick_nh = a1_nh;
        else if (a2_h) pick_nh = a2_nh;
        else           pick_nh = DEFAULT_NH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_v  <= 1'b0;
            o_h  <= 1'b0;
            o_nh <= DEFAULT_NH;
        end else begin
            o_v  <= both_v;
            o_h  <= pick_h;
            o_nh <= pick_nh;
        end
    end
endmodule

// File: rtl/lpm_res_errfsm.sv
module lpm_res_errfsm
    import lpm_res_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_mis,
    output logic             err
);
    err_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: if (|lane_mis) state_d = ST_FAULT;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    always_comb begin
        err = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/lpm_pair_resolver.sv
module lpm_pair_resolver #(
    parameter int              LANES      = 2,
    parameter int              NH_W       = 8,
    parameter int              DLY        = 2,
    parameter int              DELAY_SET  = 2,
    parameter logic [NH_W-1:0] DEFAULT_NH = 8'hEE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      s1_valid,
    input  logic [LANES-1:0]      s1_hit,
    input  logic [LANES*NH_W-1:0] s1_nh,
    input  logic [LANES-1:0]      s2_valid,
    input  logic [LANES-1:0]      s2_hit,
    input  logic [LANES*NH_W-1:0] s2_nh,
    output logic [LANES-1:0]      res_valid,
    output logic [LANES-1:0]      res_hit,
    output logic [LANES*NH_W-1:0] res_nh,
    output logic                  err_sticky
);
    localparam int PW = NH_W + 2;

    logic [LANES-1:0]      al_v1, al_h1, al_v2, al_h2, lane_mis;
    logic [LANES*NH_W-1:0] al_nh1, al_nh2;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [PW-1:0] raw1, raw2, dl1, dl2;
            assign raw1 = {s1_valid[l], s1_hit[l], s1_nh[l*NH_W +: NH_W]};
            assign raw2 = {s2_valid[l], s2_hit[l], s2_nh[l*NH_W +: NH_W]};

            if (DELAY_SET == 1) begin : g_d1
                lpm_res_delay #(.W(PW), .DEPTH(DLY)) u_dly (
                    .clk(clk), .rst_n(rst_n), .din(raw1), .dout(dl1));
                assign dl2 = raw2;
            end else begin : g_d2
                lpm_res_delay #(.W(PW), .DEPTH(DLY)) u_dly (
                    .clk(clk), .rst_n(rst_n), .din(raw2), .dout(dl2));
                assign dl1 = raw1;
            end

            assign {al_v1[l], al_h1[l], al_nh1[l*NH_W +: NH_W]} = dl1;
            assign {al_v2[l], al_h2[l], al_nh2[l*NH_W +: NH_W]} = dl2;

            lpm_res_lane #(.NH_W(NH_W), .DEFAULT_NH(DEFAULT_NH)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .a1_v    (al_v1[l]),
                .a1_h    (al_h1[l]),
                .a1_nh   (al_nh1[l*NH_W +: NH_W]),
                .a2_v    (al_v2[l]),
                .a2_h    (al_h2[l]),
                .a2_nh   (al_nh2[l*NH_W +: NH_W]),
                .mismatch(lane_mis[l]),
                .o_v     (res_valid[l]),
                .o_h     (res_hit[l]),
                .o_nh    (res_nh[l*NH_W +: NH_W])
            );
        end
    endgenerate

    lpm_res_errfsm #(.LANES(LANES)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_mis(lane_mis),
        .err     (err_sticky)
    );
endmodule

// File: rtl/lpm_pair_resolver_chk.sv
module lpm_pair_resolver_chk #(
    parameter int              LANES      = 2,
    parameter int              NH_W       = 8,
    parameter logic [NH_W-1:0] DEFAULT_NH = 8'hEE
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [LANES-1:0]      al_v1,
    input logic [LANES-1:0]      al_h1,
    input logic [LANES*NH_W-1:0] al_nh1,
    input logic [LANES-1:0]      al_v2,
    input logic [LANES-1:0]      al_h2,
    input logic [LANES-1:0]      res_valid,
    input logic [LANES-1:0]      res_hit,
    input logic [LANES*NH_W-1:0] res_nh,
    input logic                  err_sticky
);
    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_chk
            // R2
            set1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (al_v1[l] && al_v2[l] && al_h1[l]) |=>
                (res_hit[l] && res_nh[l*NH_W +: NH_W] == $past(al_nh1[l*NH_W +: NH_W])));
            // R4
            default_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid[l] && !res_hit[l]) |-> (res_nh[l*NH_W +: NH_W] == DEFAULT_NH));
            // R7
            hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !res_valid[l] |-> !res_hit[l]);
            // R8
            mismatch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (al_v1[l] != al_v2[l]) |=> err_sticky);
        end
    endgenerate
endmodule

bind lpm_pair_resolver lpm_pair_resolver_chk #(
    .LANES(LANES), .NH_W(NH_W), .DEFAULT_NH(DEFAULT_NH)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .al_v1(al_v1), .al_h1(al_h1), .al_nh1(al_nh1),
    .al_v2(al_v2), .al_h2(al_h2),
    .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh),
    .err_sticky(err_sticky)
);

// File: tb/lpm_pair_resolver_bench.sv
module lpm_pair_resolver_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         LANES = 2;
    localparam int         NH_W  = 8;
    localparam int         DLY   = 2;
    localparam logic [7:0] DEF   = 8'hEE;
    localparam int         NV    = 6;

    function automatic logic [17:0] mk(logic h1, logic [7:0] n1, logic h2, logic [7:0] n2);
        return {h1, n1, h2, n2};
    endfunction

    // each entry: {lane1, lane0}, lane = {s1_hit, s1_nh, s2_hit, s2_nh}
    localparam logic [35:0] VEC [NV] = '{
        {mk(1'b0, 8'h33, 1'b1, 8'h44), mk(1'b1, 8'h11, 1'b1, 8'h22)},
        {mk(1'b1, 8'h77, 1'b0, 8'h88), mk(1'b0, 8'h55, 1'b0, 8'h66)},
        {mk(1'b1, 8'hA0, 1'b1, 8'hB0), mk(1'b0, 8'h01, 1'b1, 8'h02)},
        {mk(1'b0, 8'h12, 1'b0, 8'h34), mk(1'b1, 8'hC3, 1'b0, 8'h00)},
        {mk(1'b0, 8'h00, 1'b1, 8'hEE), mk(1'b1, 8'hFF, 1'b1, 8'h00)},
        {mk(1'b1, 8'h5A, 1'b1, 8'hA5), mk(1'b0, 8'h99, 1'b0, 8'h99)}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [LANES-1:0]      s1_valid, s1_hit, s2_valid, s2_hit;
    logic [LANES*NH_W-1:0] s1_nh, s2_nh;
    logic [LANES-1:0]      res_valid, res_hit;
    logic [LANES*NH_W-1:0] res_nh;
    logic                  err_sticky;
    int                    checks = 0;
    int                    bad = 0;
    bit                    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_pair_resolver #(.LANES(LANES), .NH_W(NH_W), .DLY(DLY),
                        .DELAY_SET(2), .DEFAULT_NH(DEF)) u_lpm_pair_resolver (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_nh(s1_nh),
        .s2_valid(s2_valid), .s2_hit(s2_hit), .s2_nh(s2_nh),
        .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh),
        .err_sticky(err_sticky));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        s1_valid = '0; s1_hit = '0; s1_nh = '0;
        s2_valid = '0; s2_hit = '0; s2_nh = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(res_valid), 32'h0);
        check("R1 hit", 32'(res_hit), 32'h0);
        check("R1 err", 32'(err_sticky), 32'h0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7: table walk, set 2 fed DLY cycles ahead of set 1
        for (int c = 0; c <= NV + DLY; c++) begin
            @(negedge clk);
            if (c - 1 - DLY >= 0 && c - 1 - DLY < NV) begin
                for (int l = 0; l < LANES; l++) begin
                    logic [17:0] e;
                    logic        eh;
                    logic [7:0]  en;
                    e  = VEC[c-1-DLY][l*18 +: 18];
                    eh = e[17] | e[8];
                    en = e[17] ? e[16:9] : (e[8] ? e[7:0] : DEF);
                    check("R5 R7 valid", 32'(res_valid[l]), 32'h1);
                    check(e[17] ? "R2 R6 hit" : "R3 R4 R6 hit", 32'(res_hit[l]), 32'(eh));
                    check(e[17] ? "R2 R6 nh" : (e[8] ? "R3 R6 nh" : "R4 R6 nh"),
                          32'(res_nh[l*8 +: 8]), 32'(en));
                end
            end
            idle();
            if (c < NV) begin
                for (int l = 0; l < LANES; l++) begin
                    s2_valid[l]      = 1'b1;
                    s2_hit[l]        = VEC[c][l*18 + 8];
                    s2_nh[l*8 +: 8]  = VEC[c][l*18 +: 8];
                end
            end
            if (c >= DLY && c - DLY < NV) begin
                for (int l = 0; l < LANES; l++) begin
                    s1_valid[l]      = 1'b1;
                    s1_hit[l]        = VEC[c-DLY][l*18 + 17];
                    s1_nh[l*8 +: 8]  = VEC[c-DLY][l*18 + 9 +: 8];
                end
            end
        end
        @(negedge clk);
        // R9: aligned traffic and idle never flag
        check("R9 err", 32'(err_sticky), 32'h0);
        // R7: idle gives no valid
        check("R7 idle valid", 32'(res_valid), 32'h0);

        // R8: lone first-set valid on lane 0 while set 2 stays idle
        s1_valid[0] = 1'b1; s1_hit[0] = 1'b1; s1_nh[7:0] = 8'h42;
        @(negedge clk);
        idle();
        check("R8 err rise", 32'(err_sticky), 32'h1);
        check("R7 lone valid", 32'(res_valid[0]), 32'h0);
        check("R7 lone hit", 32'(res_hit[0]), 32'h0);
        repeat (4) @(negedge clk);
        check("R8 err held", 32'(err_sticky), 32'h1);

        // R1: reset clears the fault
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 err cleared", 32'(err_sticky), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", 32'(res_valid), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule